// File: doc/BRIEF.md
# Byte-Banked Interrupt Aggregator

This block collects a set of peripheral interrupt request lines and folds them into a single interrupt output for a host processor. The sources are split into byte-wide banks. Source `8*b + j` lives in bank `b`, bit `j`. Each bank has an enable mask that the host can read and write. Each bank also has a status view that the host reads over a small byte-wide register bus. Every input first passes through a two-flop synchroniser.

All sources but one are edge-captured. A rising edge is recorded only while the source's enable bit is set, so an edge that arrives while the source is disabled is gone for good. Recorded edges are cleared as a side effect of the host reading that bank's status; there is no acknowledge write. One parameter-selected source position is a level source instead: its status bit simply mirrors the synchronised input and survives reads.

The output is a registered OR of every source that is both flagged and enabled, so the host can catch it on its rising edge. The register bus is a plain strobe interface with no back-pressure: a read strobe always returns data on the next cycle and a write strobe always completes, so no valid/ready handshake is used.

Top module: `irq_byte_aggregator`

## Requirements
- R1: After reset all enable masks, the read data and `irq_out` are zero, so no source can raise the output until enabled.
- R2: A write with `reg_sel`=1 sets bank `bank_sel`'s mask to `wr_data` (1 = enabled). A read with `reg_sel`=1 returns that mask. Banks 0, 1 and 2 are valid. A read of `bank_sel`=3 returns 0 and a write to it changes nothing.
- R3: A rising edge on edge source `8*b+j`, arriving while mask bit `j` of bank `b` is 1, sets status bit `j` of bank `b`.
- R4: Read data appears on `rd_data` in the cycle after `rd_stb`. A read with `reg_sel`=0 returns the bank's status and clears every edge-captured bit of that bank that was set when the read was sampled.
- R5: A rising edge on an edge source whose mask bit is 0 is not recorded, and setting the mask bit afterwards does not recover it.
- R6: The level source at position `LVL_SRC` (default 2: bank 0, bit 2) reports the synchronised input level in its status bit whether it is enabled or not. Status reads do not clear it.
- R7: `irq_out` is high exactly when at least one source has its status bit and its mask bit both 1. It follows that condition one clock later.
- R8: An edge that lands in the same cycle as a status read of its bank is absent from that read's data and is returned by the next status read.
- R9: Writes with `reg_sel`=0 (status) are ignored and change no status or mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | Asynchronous interrupt request lines, one per source |
| bank_sel | input | 2 | Bank selector for the register bus |
| reg_sel | input | 1 | 0 = status view, 1 = enable mask |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_stb` |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
The assertions assume `rd_stb` and `wr_stb` are never high in the same cycle. They also assume the bus fields are stable only during the strobe cycle. The random stimulus issues one bus access at a time and leaves idle cycles between accesses. It holds every input change for several cycles before the next bus access, so each edge reaches the status register before it is observed. Only the directed same-cycle case times an input edge to meet a status read on purpose.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl_out,
  output logic [WIDTH-1:0] rise_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign lvl_out  = sync_q;
  assign rise_out = sync_q & ~hist_q;
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int BANK_W  = 8,
  parameter bit HAS_LVL = 1'b0,
  parameter int LVL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lvl_in,
  input  logic [BANK_W-1:0] rise_in,
  input  logic              rd_stat,
  input  logic              wr_mask,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] stat_view,
  output logic [BANK_W-1:0] mask_view,
  output logic              pend_any
);
  localparam logic [BANK_W-1:0] LVL_VEC =
    HAS_LVL ? (BANK_W'(1) << LVL_BIT) : '0;

  logic [BANK_W-1:0] edge_q;
  logic [BANK_W-1:0] mask_q;
  logic [BANK_W-1:0] edge_keep;
  logic [BANK_W-1:0] edge_nxt;

  // Clearing uses the bits present now; a new capture is OR'ed in after.
  always_comb begin
    edge_keep = rd_stat ? '0 : edge_q;
    edge_nxt  = (edge_keep | (rise_in & mask_q)) & ~LVL_VEC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      mask_q <= '0;
    end else begin
      edge_q <= edge_nxt;
      if (wr_mask) mask_q <= wr_data;
    end
  end

  assign stat_view = (edge_q & ~LVL_VEC) | (lvl_in & LVL_VEC);
  assign mask_view = mask_q;
  assign pend_any  = |(stat_view & mask_q);
endmodule

// File: rtl/irq_byte_aggregator.sv
module irq_byte_aggregator #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int LVL_SRC   = 2,
  parameter int SEL_W     = 2,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [SEL_W-1:0]   bank_sel,
  input  logic               reg_sel,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [BANK_W-1:0]  wr_data,
  output logic [BANK_W-1:0]  rd_data,
  output logic               irq_out
);
  import irq_agg_pkg::*;

  localparam int LVL_BANK = LVL_SRC / BANK_W;
  localparam int LVL_BIT  = LVL_SRC % BANK_W;

  logic [NUM_SRC-1:0]   sync_lvl;
  logic [NUM_SRC-1:0]   sync_rise;
  logic [NUM_SRC-1:0]   status_flat;
  logic [NUM_SRC-1:0]   mask_flat;
  logic [NUM_BANKS-1:0] pend_vec;
  logic                 sel_ok;
  logic [BANK_W-1:0]    rd_mux;
  logic                 irq_q;
  logic [BANK_W-1:0]    rd_q;

  assign sel_ok = (int'(bank_sel) < NUM_BANKS);

  irq_agg_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .lvl_out  (sync_lvl),
    .rise_out (sync_rise)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == SEL_W'(b));

    irq_agg_bank #(
      .BANK_W  (BANK_W),
      .HAS_LVL (b == LVL_BANK),
      .LVL_BIT (LVL_BIT)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_in    (sync_lvl[b*BANK_W +: BANK_W]),
      .rise_in   (sync_rise[b*BANK_W +: BANK_W]),
      .rd_stat   (rd_stb && hit && (reg_sel == SEL_STATUS)),
      .wr_mask   (wr_stb && hit && (reg_sel == SEL_MASK)),
      .wr_data   (wr_data),
      .stat_view (status_flat[b*BANK_W +: BANK_W]),
      .mask_view (mask_flat[b*BANK_W +: BANK_W]),
      .pend_any  (pend_vec[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ok) begin
      if (reg_sel == SEL_MASK) rd_mux = mask_flat[int'(bank_sel)*BANK_W +: BANK_W];
      else                     rd_mux = status_flat[int'(bank_sel)*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rd_stb) rd_q <= rd_mux;
      irq_q <= |pend_vec;
    end
  end

  assign rd_data = rd_q;
  assign irq_out = irq_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int LVL_SRC   = 2,
  parameter int SEL_W     = 2,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   bank_sel,
  input logic               reg_sel,
  input logic               rd_stb,
  input logic               wr_stb,
  input logic [BANK_W-1:0]  wr_data,
  input logic [BANK_W-1:0]  rd_data,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] mask_flat,
  input logic [NUM_SRC-1:0] status_flat,
  input logic [NUM_SRC-1:0] sync_lvl
);
  localparam logic [NUM_SRC-1:0] LVL_ONE = NUM_SRC'(1) << LVL_SRC;

  // R2: an unused bank reads as zero
  a_r2_spare_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && int'(bank_sel) >= NUM_BANKS) |=> (rd_data == '0));

  // R2: a mask write lands in the selected bank
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_sel && int'(bank_sel) < NUM_BANKS) |=>
      (mask_flat[int'($past(bank_sel))*BANK_W +: BANK_W] == $past(wr_data)));

  // R9: status writes leave the masks alone
  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !reg_sel) |=> $stable(mask_flat));

  // R5: a new edge capture needs the mask bit set in the capture cycle
  a_r5_masked_edge_lost: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_flat & ~$past(status_flat) & ~$past(mask_flat) & ~LVL_ONE) == '0));

  // R6: the level bit in a status read mirrors the synchronised level
  a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !reg_sel && int'(bank_sel) == LVL_SRC / BANK_W) |=>
      (rd_data[LVL_SRC % BANK_W] == $past(sync_lvl[LVL_SRC])));

  // R7: with nothing enabled the output drops on the next cycle
  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '0) |=> !irq_out);

  // R4: read data only changes after a read strobe
  a_r4_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind irq_byte_aggregator irq_agg_checker #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .LVL_SRC   (LVL_SRC),
  .SEL_W     (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bank_sel    (bank_sel),
  .reg_sel     (reg_sel),
  .rd_stb      (rd_stb),
  .wr_stb      (wr_stb),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .irq_out     (irq_out),
  .mask_flat   (mask_flat),
  .status_flat (status_flat),
  .sync_lvl    (sync_lvl)
);

// File: tb/test_irq_byte_aggregator.sv
module test_irq_byte_aggregator;
  localparam int LVL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_in = '0;
  logic [1:0]  bank_sel = '0;
  logic        reg_sel = 1'b0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq_out;

  int checks = 0;
  int failures = 0;

  logic [23:0] m_edge = '0;
  logic [23:0] m_mask = '0;

  always #10 clk = ~clk;

  irq_byte_aggregator i_irq_byte_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bank_sel(bank_sel),
    .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [23:0] view_all();
    logic [23:0] v = m_edge & ~(24'd1 << LVL);
    v[LVL] = irq_in[LVL];
    return v;
  endfunction

  function automatic logic exp_irq();
    return |(view_all() & m_mask);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] b, input logic rs, output logic [7:0] d);
    bank_sel = b; reg_sel = rs; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic bus_write(input logic [1:0] b, input logic rs, input logic [7:0] d);
    bank_sel = b; reg_sel = rs; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (rs && b != 2'd3) m_mask[b*8 +: 8] = d;
  endtask

  task automatic set_inputs(input logic [23:0] v);
    logic [23:0] rises = v & ~irq_in & m_mask;
    rises[LVL] = 1'b0;
    m_edge = m_edge | rises;
    irq_in = v;
    idle(4);
  endtask

  task automatic read_status(input logic [1:0] b, input string req);
    logic [7:0] d;
    logic [23:0] v = view_all();
    bus_read(b, 1'b0, d);
    check(req, d, (b == 2'd3) ? 8'h00 : v[b*8 +: 8]);
    if (b != 2'd3) m_edge[b*8 +: 8] = 8'h00;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1D5E));
    irq_in = 24'h000004;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state, level source high but disabled
    check("R1 irq_out", irq_out, 1'b0);
    check("R1 rd_data", rd_data, 8'h00);
    for (int b = 0; b < 3; b++) begin
      bus_read(2'(b), 1'b1, d);
      check("R1 mask", d, 8'h00);
    end

    // R6: level visible while masked, no irq, not cleared by read
    read_status(2'd0, "R6 level masked");
    read_status(2'd0, "R6 level survives read");
    check("R6 irq masked", irq_out, 1'b0);
    bus_write(2'd0, 1'b1, 8'h04);
    idle(2);
    check("R7 level enabled", irq_out, 1'b1);
    set_inputs(24'h000000);
    check("R7 level drops", irq_out, 1'b0);

    // R5: edge while masked lost even after enabling
    set_inputs(24'h010000);
    bus_write(2'd2, 1'b1, 8'h01);
    idle(2);
    check("R5 irq", irq_out, 1'b0);
    read_status(2'd2, "R5 status");

    // R3/R4: edge captured, read clears
    set_inputs(24'h000000);
    set_inputs(24'h010000);
    check("R3 irq", irq_out, 1'b1);
    read_status(2'd2, "R3 status");
    idle(2);
    check("R4 irq cleared", irq_out, 1'b0);
    read_status(2'd2, "R4 cleared");

    // R2: mask readback and spare bank
    bus_write(2'd1, 1'b1, 8'hA5);
    bus_read(2'd1, 1'b1, d);
    check("R2 mask readback", d, 8'hA5);
    bus_write(2'd3, 1'b1, 8'hFF);
    bus_read(2'd3, 1'b1, d);
    check("R2 spare bank", d, 8'h00);

    // R9: status write ignored
    bus_write(2'd1, 1'b0, 8'hFF);
    bus_read(2'd1, 1'b1, d);
    check("R9 mask kept", d, 8'hA5);
    read_status(2'd1, "R9 status kept");

    // R8: edge in the read cycle survives to the next read
    bus_write(2'd0, 1'b1, 8'h24);
    read_status(2'd0, "R8 pre-clear");
    irq_in[5] = 1'b1;
    idle(2);
    bus_read(2'd0, 1'b0, d);
    check("R8 same-cycle read", d, 8'h00);
    bus_read(2'd0, 1'b0, d);
    check("R8 next read", d, 8'h20);

    // Random mix (R3 R4 R5 R7 R9)
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      logic [1:0] b = 2'($urandom_range(0, 3));
      case (op)
        0: set_inputs(irq_in ^ (24'd1 << $urandom_range(0, 23)));
        1: bus_write(b, 1'b1, 8'($urandom));
        2: read_status(b, "R4 random status");
        3: begin
          bus_read(b, 1'b1, d);
          check("R2 random mask", d, (b == 2'd3) ? 8'h00 : m_mask[b*8 +: 8]);
        end
        default: bus_write(b, 1'b0, 8'($urandom));
      endcase
      idle(3);
      check("R7 random irq", irq_out, exp_irq());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule